// File: doc/BRIEF.md
# Entropy Sampling Register Controller

A bus-mapped controller that turns a one-bit entropy stream into 128-bit random results. Software programs how many clocks pass between two taken bits, then issues a start command. The controller takes one bit from the `ent_bit` input every programmed interval and shifts it into a result register. When all bits are in, it raises a valid flag. Software polls that flag or waits for the level interrupt, reads the four result words, and writes the status register to acknowledge. The acknowledge clears the result so that stale entropy cannot be read twice.

Only one sampling cycle runs at a time. An abort command drops a partial cycle. A start issued while a result is waiting is remembered and begins at the moment the result is acknowledged. The noise source itself sits outside the block. The bus port is a plain single-cycle read/write port with word-aligned byte addresses and read data registered one clock after the request.

Top module: `ent_reg_ctrl`

## Requirements
- R1: After reset, status reads 0, all four result words read 0, the sample-interval register reads 1, the interrupt-enable register reads 0 and `irq` is 0.
- R2: Writing the value 1 to the command register (byte offset 0x10) from idle takes one bit every N clocks, where N is the interval register. If the write is sampled at edge s, bit j (j=0..127) is taken at edge s+(j+1)N. The valid flag is set by edge s+128N. The first taken bit lands in bit 31 of the word at offset 12, and the last lands in bit 0 of the word at offset 0. Result bit 127-j holds bit j, and the word at offset 4k holds result bits 32k+31..32k.
- R3: Status (offset 0x14) bit 0 reflects the valid flag and its other bits read 0. The result words at offsets 0, 4, 8 and 12 read 0 while the flag is clear.
- R4: Writing the value 2 to the command register during a cycle stops it. Valid is not raised, and a later start begins collection afresh.
- R5: Writing a value with bit 0 set to the status register while a result is waiting clears the valid flag and all result words.
- R6: A start command during a running cycle is ignored, and the cycle finishes at its original edge with its original bits.
- R7: A start command while a result is waiting leaves the result unchanged. A new cycle begins at the acknowledge edge.
- R8: The interval register (offset 0x18) stores writes of 0 as 1 and writes above 231 as 231, and reads back the stored value.
- R9: `irq` is a registered level equal to the valid flag ANDed with bit 0 of the interrupt-enable register (offset 0x1C), one clock later.
- R10: Read data appears the clock after `rd_en`. The command register reads 0. Command values other than 1 and 2 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one clock per access |
| rd_en | input | 1 | Read strobe, one clock per access |
| addr | input | ADDR_W (5) | Byte address, word aligned |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| ent_bit | input | 1 | Entropy bit stream from the noise source |
| irq | output | 1 | Level interrupt, result waiting and enabled |

## Verification
The bench builds the block with its defaults: four 32-bit words, a 5-bit address and an interval ceiling of 231. With these values both clamp boundaries (0 and values above 231) can be reached through the interval register. A full 231-clock cycle fits in about 30 thousand clocks, so the slowest interval is run end to end alongside random short intervals of 1 to 6. Logging every entropy bit at each edge lets the bench rebuild the exact 128-bit result and check the valid edge to the clock for each interval.

// File: rtl/ent_pkg.sv
package ent_pkg;
  localparam logic [31:0] CMD_START = 32'd1;
  localparam logic [31:0] CMD_ABORT = 32'd2;

  typedef enum logic [1:0] {
    SMP_IDLE = 2'd0,
    SMP_RUN  = 2'd1,
    SMP_FULL = 2'd2
  } smp_state_t;

  // bring a requested interval into the legal 1..maxv range
  function automatic logic [31:0] clamp_clks(input logic [31:0] v, input logic [31:0] maxv);
    if (v == 32'd0)
      return 32'd1;
    else if (v > maxv)
      return maxv;
    else
      return v;
  endfunction
endpackage

// File: rtl/ent_cfg_regs.sv
module ent_cfg_regs #(
  parameter int unsigned MAX_CLKS = 231,
  parameter int unsigned CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_cfg,
  input  logic             wr_mask,
  input  logic [31:0]      wdata,
  output logic [CNT_W-1:0] cfg_clks,
  output logic             mask
);
  import ent_pkg::*;

  logic [31:0] clamped;
  assign clamped = clamp_clks(wdata, 32'(MAX_CLKS));

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_clks <= CNT_W'(1);
      mask     <= 1'b0;
    end else begin
      if (wr_cfg)  cfg_clks <= CNT_W'(clamped);
      if (wr_mask) mask     <= wdata[0];
    end
  end

  assert_cfg_range_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg_clks >= CNT_W'(1)) && (32'(cfg_clks) <= 32'(MAX_CLKS)));
endmodule

// File: rtl/ent_sampler.sv
module ent_sampler #(
  parameter int unsigned TOTAL_BITS = 128,
  parameter int unsigned CNT_W      = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_cmd,
  input  logic                  abort_cmd,
  input  logic                  ack_cmd,
  input  logic [CNT_W-1:0]      cfg_clks,
  input  logic                  ent_bit,
  output logic                  valid_o,
  output logic [TOTAL_BITS-1:0] data_o
);
  import ent_pkg::*;

  localparam int unsigned BIT_W = $clog2(TOTAL_BITS);

  smp_state_t            state_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [BIT_W-1:0]      nbit_q;
  logic [TOTAL_BITS-1:0] shreg_q;
  logic                  pend_q;
  logic                  tick;
  logic                  last_bit;

  assign tick     = (cnt_q == cfg_clks - CNT_W'(1));
  assign last_bit = (nbit_q == BIT_W'(TOTAL_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SMP_IDLE;
      cnt_q   <= '0;
      nbit_q  <= '0;
      shreg_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      case (state_q)
        SMP_IDLE: begin
          if (start_cmd) begin
            state_q <= SMP_RUN;
            cnt_q   <= '0;
            nbit_q  <= '0;
            shreg_q <= '0;
          end
        end
        SMP_RUN: begin
          if (abort_cmd) begin
            state_q <= SMP_IDLE;
            shreg_q <= '0;
          end else if (tick) begin
            cnt_q   <= '0;
            shreg_q <= {shreg_q[TOTAL_BITS-2:0], ent_bit};
            if (last_bit) begin
              state_q <= SMP_FULL;
              nbit_q  <= '0;
            end else begin
              nbit_q <= nbit_q + BIT_W'(1);
            end
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        SMP_FULL: begin
          if (ack_cmd) begin
            shreg_q <= '0;
            cnt_q   <= '0;
            nbit_q  <= '0;
            pend_q  <= 1'b0;
            state_q <= pend_q ? SMP_RUN : SMP_IDLE;
          end else if (start_cmd) begin
            pend_q <= 1'b1;
          end else if (abort_cmd) begin
            pend_q <= 1'b0;
          end
        end
        default: state_q <= SMP_IDLE;
      endcase
    end
  end

  assign valid_o = (state_q == SMP_FULL);
  assign data_o  = shreg_q;

  assert_valid_from_run_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_o) |-> $past(state_q == SMP_RUN));
  assert_abort_stops_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == SMP_RUN && abort_cmd) |=> (state_q == SMP_IDLE) && !valid_o);
  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == SMP_FULL && ack_cmd && !pend_q) |=> !valid_o && (data_o == '0));
  assert_pending_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == SMP_FULL && !ack_cmd) |=> valid_o && $stable(shreg_q));
endmodule

// File: rtl/ent_rd_mux.sv
module ent_rd_mux #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned IDX_W     = 3,
  parameter int unsigned CNT_W     = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rd,
  input  logic [IDX_W-1:0]            idx,
  input  logic                        valid,
  input  logic [NUM_WORDS*WORD_W-1:0] data,
  input  logic [CNT_W-1:0]            cfg_clks,
  input  logic                        mask,
  output logic [WORD_W-1:0]           rdata
);
  localparam int unsigned WSEL_W   = $clog2(NUM_WORDS);
  localparam int unsigned STAT_IDX = NUM_WORDS + 1;
  localparam int unsigned CFG_IDX  = NUM_WORDS + 2;
  localparam int unsigned MASK_IDX = NUM_WORDS + 3;

  logic [WORD_W-1:0] words [NUM_WORDS];
  logic [WORD_W-1:0] rd_next;

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    assign words[g] = data[g*WORD_W +: WORD_W];
  end

  always_comb begin
    rd_next = '0;
    if (int'(idx) < NUM_WORDS)
      rd_next = valid ? words[idx[WSEL_W-1:0]] : '0;
    else if (idx == IDX_W'(STAT_IDX))
      rd_next = {{(WORD_W-1){1'b0}}, valid};
    else if (idx == IDX_W'(CFG_IDX))
      rd_next = {{(WORD_W-CNT_W){1'b0}}, cfg_clks};
    else if (idx == IDX_W'(MASK_IDX))
      rd_next = {{(WORD_W-1){1'b0}}, mask};
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_next;
  end

  assert_rd_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (rd && int'(idx) < NUM_WORDS && !valid) |=> (rdata == '0));
endmodule

// File: rtl/ent_reg_ctrl.sv
module ent_reg_ctrl #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned MAX_CLKS  = 231
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              ent_bit,
  output logic              irq
);
  import ent_pkg::*;

  localparam int unsigned IDX_W      = ADDR_W - 2;
  localparam int unsigned TOTAL_BITS = NUM_WORDS * WORD_W;
  localparam int unsigned CNT_W      = $clog2(MAX_CLKS + 1);
  localparam int unsigned CTRL_IDX   = NUM_WORDS;
  localparam int unsigned STAT_IDX   = NUM_WORDS + 1;
  localparam int unsigned CFG_IDX    = NUM_WORDS + 2;
  localparam int unsigned MASK_IDX   = NUM_WORDS + 3;

  logic [IDX_W-1:0]      idx;
  logic                  aligned;
  logic                  wr_ok;
  logic                  start_cmd, abort_cmd, ack_cmd;
  logic                  wr_cfg, wr_mask;
  logic [CNT_W-1:0]      cfg_clks;
  logic                  mask;
  logic                  valid;
  logic [TOTAL_BITS-1:0] data;

  assign idx       = addr[ADDR_W-1:2];
  assign aligned   = (addr[1:0] == 2'b00);
  assign wr_ok     = wr_en && aligned;
  assign start_cmd = wr_ok && (idx == IDX_W'(CTRL_IDX)) && (wdata == CMD_START);
  assign abort_cmd = wr_ok && (idx == IDX_W'(CTRL_IDX)) && (wdata == CMD_ABORT);
  assign ack_cmd   = wr_ok && (idx == IDX_W'(STAT_IDX)) && wdata[0];
  assign wr_cfg    = wr_ok && (idx == IDX_W'(CFG_IDX));
  assign wr_mask   = wr_ok && (idx == IDX_W'(MASK_IDX));

  ent_cfg_regs #(.MAX_CLKS(MAX_CLKS), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_cfg(wr_cfg), .wr_mask(wr_mask),
    .wdata(wdata), .cfg_clks(cfg_clks), .mask(mask)
  );

  ent_sampler #(.TOTAL_BITS(TOTAL_BITS), .CNT_W(CNT_W)) u_smp (
    .clk(clk), .rst(rst), .start_cmd(start_cmd), .abort_cmd(abort_cmd),
    .ack_cmd(ack_cmd), .cfg_clks(cfg_clks), .ent_bit(ent_bit),
    .valid_o(valid), .data_o(data)
  );

  ent_rd_mux #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_rd (
    .clk(clk), .rst(rst), .rd(rd_en && aligned), .idx(idx), .valid(valid),
    .data(data), .cfg_clks(cfg_clks), .mask(mask), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= valid && mask;
  end

  assert_irq_needs_valid_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(valid));
endmodule

// File: tb/sim_ent_reg_ctrl.sv
`timescale 1ns/1ps
module sim_ent_reg_ctrl;
  localparam int A_CTRL = 16;
  localparam int A_STAT = 20;
  localparam int A_CFG  = 24;
  localparam int A_MASK = 28;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ent_bit = 1'b0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int edge_cnt = 0;
  int last_wr = 0;
  logic ent_log [0:65535];

  ent_reg_ctrl u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ent_bit(ent_bit), .irq(irq)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    ent_log[edge_cnt & 65535] <= ent_bit;
    edge_cnt <= edge_cnt + 1;
  end

  always @(negedge clk) ent_bit <= 1'($urandom() & 1);

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    if (edge_cnt > 190000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got %0d edges, expected fewer than 190000", edge_cnt);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1'b1; addr = 5'(a); wdata = d; last_wr = edge_cnt;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    rd_en = 1'b1; addr = 5'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle_to(input int e);
    while (edge_cnt < e) @(negedge clk);
  endtask

  function automatic logic [127:0] exp_data(input int s, input int n);
    logic [127:0] d;
    for (int j = 0; j < 128; j++) d[127-j] = ent_log[(s + (j+1)*n) & 65535];
    return d;
  endfunction

  task automatic chk_words(input string req, input int s, input int n);
    logic [127:0] e;
    logic [31:0] d;
    e = exp_data(s, n);
    for (int w = 0; w < 4; w++) begin
      rd(w*4, d);
      chk(req, d, e[32*w +: 32]);
    end
  endtask

  task automatic chk_zero_words(input string req);
    logic [31:0] d;
    for (int w = 0; w < 4; w++) begin
      rd(w*4, d);
      chk(req, d, 32'h0);
    end
  endtask

  // wait for the cycle begun at edge s, check valid edge, irq and words
  task automatic finish_cycle(input int s, input int n, input bit m);
    logic [31:0] d;
    int v;
    v = s + 128*n;
    idle_to(v);
    rd(A_STAT, d); chk("R2 valid not before edge", d, 32'h0);
    chk("R9 irq lags", {31'h0, irq}, 32'h0);
    rd(A_STAT, d); chk("R2 R3 valid at edge", d, 32'h1);
    chk("R9 irq level", {31'h0, irq}, {31'h0, m});
    chk_words("R2 result words", s, n);
  endtask

  task automatic ack_and_check();
    logic [31:0] d;
    wr(A_STAT, 32'h1);
    rd(A_STAT, d); chk("R5 valid cleared", d, 32'h0);
    chk("R9 irq cleared", {31'h0, irq}, 32'h0);
    chk_zero_words("R5 R3 words cleared");
  endtask

  initial begin
    logic [31:0] d;
    int s, n, p;
    bit m;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(A_STAT, d); chk("R1 status", d, 32'h0);
    rd(A_CFG, d);  chk("R1 interval", d, 32'h1);
    rd(A_MASK, d); chk("R1 irq enable", d, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk_zero_words("R1 words");

    // R8 clamp
    wr(A_CFG, 32'd0);   rd(A_CFG, d); chk("R8 zero to one", d, 32'd1);
    wr(A_CFG, 32'd500); rd(A_CFG, d); chk("R8 saturate", d, 32'd231);
    wr(A_CFG, 32'hFFFF_FFFF); rd(A_CFG, d); chk("R8 saturate max", d, 32'd231);
    wr(A_CFG, 32'd231); rd(A_CFG, d); chk("R8 top value", d, 32'd231);
    wr(A_CFG, 32'd7);   rd(A_CFG, d); chk("R8 mid value", d, 32'd7);

    // R2 / R9 basic cycle, interval 1, irq enabled
    wr(A_CFG, 32'd1);
    wr(A_MASK, 32'd1);
    wr(A_CTRL, 32'd1); s = last_wr;
    rd(A_8(), d); chk("R3 words zero while running", d, 32'h0);
    finish_cycle(s, 1, 1'b1);
    ack_and_check();

    // R4 abort then restart
    wr(A_CFG, 32'd2);
    wr(A_CTRL, 32'd1); s = last_wr;
    idle_to(s + 40);
    wr(A_CTRL, 32'd2);
    idle_to(s + 128*2 + 10);
    rd(A_STAT, d); chk("R4 no valid after abort", d, 32'h0);
    chk_zero_words("R4 words after abort");
    wr(A_CTRL, 32'd1); s = last_wr;
    finish_cycle(s, 2, 1'b1);
    ack_and_check();

    // R6 start while running is ignored
    wr(A_CFG, 32'd3);
    wr(A_CTRL, 32'd1); s = last_wr;
    idle_to(s + 50);
    wr(A_CTRL, 32'd1);
    finish_cycle(s, 3, 1'b1);

    // R7 start while result waiting
    wr(A_CTRL, 32'd1);
    idle_to(edge_cnt + 500);
    rd(A_STAT, d); chk("R7 still valid", d, 32'h1);
    chk_words("R7 result kept", s, 3);
    wr(A_STAT, 32'h1); p = last_wr;
    rd(A_STAT, d); chk("R7 cleared by ack", d, 32'h0);
    finish_cycle(p, 3, 1'b1);
    ack_and_check();

    // R10 other command values ignored, command reads zero
    wr(A_CTRL, 32'd3); s = last_wr;
    idle_to(s + 400);
    rd(A_STAT, d); chk("R10 bad command ignored", d, 32'h0);
    rd(A_CTRL, d); chk("R10 command reads zero", d, 32'h0);

    // random intervals and irq enable
    for (int it = 0; it < 6; it++) begin
      n = 1 + int'($urandom() % 6);
      m = 1'($urandom() & 1);
      wr(A_CFG, 32'(n));
      wr(A_MASK, {31'h0, m});
      wr(A_CTRL, 32'd1); s = last_wr;
      finish_cycle(s, n, m);
      ack_and_check();
    end

    // slowest interval end to end
    wr(A_CFG, 32'd231);
    wr(A_MASK, 32'd0);
    wr(A_CTRL, 32'd1); s = last_wr;
    finish_cycle(s, 231, 1'b0);
    ack_and_check();

    summary();
    $finish;
  end

  function automatic int A_8();
    return 8;
  endfunction
endmodule